// File: doc/BRIEF.md
# Touch-Screen Pen-Interrupt and Power-Mode Controller

This block is the digital control slice of a resistive touch-screen converter. Every control byte carries a two-bit power code and a channel class. The block turns these into enables for the voltage reference, the converter and the Y-minus ground driver. It also drives the active-low pen-interrupt pin from a comparator that senses whether the X+ node has been pulled to ground through the panel.

A central state machine has four states. `ST_IDLE_ARMED` is the idle state with the pen interrupt live. `ST_IDLE_QUIET` is the idle state with the interrupt disabled. `ST_CONV_POS` is a position (X, Y or Z) measurement in progress. `ST_CONV_AUX` is a battery, auxiliary-input or temperature measurement in progress. Its transitions are:
- load with the position class goes to `ST_CONV_POS`, from any state.
- load with the auxiliary class goes to `ST_CONV_AUX`, from any state.
- end of conversion with power bit 0 clear goes to `ST_IDLE_ARMED`. This is the re-arm.
- end of conversion with power bit 0 set goes to `ST_IDLE_QUIET`.
- conversion-active dropping without an end strobe goes to `ST_IDLE_QUIET`. This is the abort.

A load has priority over an end strobe in the same cycle, and an end strobe has priority over an abort.

The reference enable is captured when a control byte is loaded, which is the moment the converter goes busy. Switching the reference off therefore takes a further control write once the measurement that needed it has finished.

Top module: `pen_pwr_ctrl`

## Requirements
- R1: After reset the block behaves as though power code 00 had been loaded: state `ST_IDLE_ARMED`, Y-minus driver on, pull-up connected, reference off, converter off, and the pen pin tracking the touch input.
- R2: In `ST_IDLE_ARMED` the pen pin equals the inverse of `touch_raw` as sampled two rising edges earlier. A touch (`touch_raw`=1) drives the pin low.
- R3: From the cycle after a load with `ctl_meas_pos`=1 until the conversion ends, the pen pin is 0, the pull-up is disconnected (0) and the Y-minus driver is off.
- R4: From the cycle after a load with `ctl_meas_pos`=0 until the conversion ends, the pen pin is 1, the pull-up stays connected and the Y-minus driver is off.
- R5: After a conversion ends and the latest loaded code has bit 0 (`ctl_pd[0]`) set, the pen pin stays 1 and the Y-minus driver stays off whatever `touch_raw` does. This lasts until a later byte with bit 0 clear has completed its conversion.
- R6: When `eoc_strobe` is seen during a conversion, with no load in the same cycle and bit 0 of the latest code clear, the block is in `ST_IDLE_ARMED` from the next cycle.
- R7: `ref_en` equals bit 1 of the most recently loaded `ctl_pd`. It changes only in the cycle after a load.
- R8: `adc_en` is 1 whenever bit 0 of the latest code is set. Otherwise it is 1 only while a conversion state is active.
- R9: If `conv_active` is 0 during a conversion state, with no load and no end strobe in that cycle, the block moves to `ST_IDLE_QUIET` without re-arming.
- R10: A load that arrives during a conversion restarts the conversion with the new byte's class and power code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_load | input | 1 | One-cycle strobe: a control byte has been latched and conversion starts |
| ctl_pd | input | 2 | Power code of that byte; bit 1 = reference on, bit 0 = interrupt disabled / converter kept on |
| ctl_meas_pos | input | 1 | 1 = X/Y/Z position channel, 0 = battery/auxiliary/temperature channel |
| conv_active | input | 1 | High while the converter is busy with the current byte |
| eoc_strobe | input | 1 | One-cycle end-of-conversion pulse (clock edge after data bit 1) |
| touch_raw | input | 1 | Asynchronous comparator level, 1 = panel touched |
| pen_irq_n | output | 1 | Active-low pen interrupt pin |
| ref_en | output | 1 | Reference power enable |
| adc_en | output | 1 | Converter power enable |
| ym_drv_en | output | 1 | Y-minus ground driver enable |
| pullup_en | output | 1 | Connects the X+ pull-up to the sensing node |

## Verification
The bench targets a load arriving in the same cycle as an end strobe. A design that let the strobe win would re-arm using the stale code and lose the new measurement class. It also checks the re-arm with bit 0 clear against the disabled idle with bit 0 set, where a design that re-armed on load rather than at the end strobe would let the pin drop low during a conversion's tail. Aborted conversions are exercised to catch a design that wrongly re-arms without an end strobe. Bursts of reference-code changes show whether `ref_en` moves at any time other than a load.

// File: rtl/pen_pwr_pkg.sv
package pen_pwr_pkg;

    localparam int PD_W = 2;

    typedef enum logic [1:0] {
        ST_IDLE_ARMED = 2'd0,
        ST_IDLE_QUIET = 2'd1,
        ST_CONV_POS   = 2'd2,
        ST_CONV_AUX   = 2'd3
    } pen_state_t;

    function automatic logic is_conv(pen_state_t s);
        return (s == ST_CONV_POS) || (s == ST_CONV_AUX);
    endfunction

endpackage

// File: rtl/pen_ctl_reg.sv
module pen_ctl_reg
    import pen_pwr_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [PD_W-1:0] pd_in,
    output logic            pd0_q,
    output logic            ref_q
);

    localparam int REF_BIT = PD_W - 1;

    // Power code captured when the converter goes busy
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pd0_q <= 1'b0;
            ref_q <= 1'b0;
        end else if (load) begin
            pd0_q <= pd_in[0];
            ref_q <= pd_in[REF_BIT];
        end
    end

    assert_ref_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (ref_q == $past(pd_in[REF_BIT])));

    assert_ref_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(ref_q));

endmodule

// File: rtl/pen_sync.sv
module pen_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);

    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= 1'b0;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[LAST];

endmodule

// File: rtl/pen_fsm.sv
module pen_fsm
    import pen_pwr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_load,
    input  logic ctl_meas_pos,
    input  logic pd0_q,
    input  logic conv_active,
    input  logic eoc_strobe,
    input  logic touch_s,
    output logic pen_irq_n,
    output logic ym_drv_en,
    output logic pullup_en,
    output logic adc_en
);

    pen_state_t state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE_ARMED;
        else        state_q <= state_d;
    end

    // Next state: load beats end strobe, end strobe beats abort
    always_comb begin
        state_d = state_q;
        if (ctl_load) begin
            state_d = ctl_meas_pos ? ST_CONV_POS : ST_CONV_AUX;
        end else begin
            unique case (state_q)
                ST_IDLE_ARMED: state_d = ST_IDLE_ARMED;
                ST_IDLE_QUIET: state_d = ST_IDLE_QUIET;
                ST_CONV_POS, ST_CONV_AUX: begin
                    if (eoc_strobe)
                        state_d = pd0_q ? ST_IDLE_QUIET : ST_IDLE_ARMED;
                    else if (!conv_active)
                        state_d = ST_IDLE_QUIET;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        pen_irq_n = 1'b1;
        ym_drv_en = 1'b0;
        pullup_en = 1'b1;
        unique case (state_q)
            ST_IDLE_ARMED: begin
                pen_irq_n = ~touch_s;
                ym_drv_en = 1'b1;
            end
            ST_IDLE_QUIET: begin
                pen_irq_n = 1'b1;
            end
            ST_CONV_POS: begin
                pen_irq_n = 1'b0;
                pullup_en = 1'b0;
            end
            ST_CONV_AUX: begin
                pen_irq_n = 1'b1;
            end
        endcase
        adc_en = pd0_q | is_conv(state_q);
    end

    assert_pos_forced_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_load && ctl_meas_pos) |=> (!pen_irq_n && !pullup_en && !ym_drv_en));

    assert_aux_forced_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_load && !ctl_meas_pos) |=> (pen_irq_n && pullup_en && !ym_drv_en));

    assert_quiet_after_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (is_conv(state_q) && eoc_strobe && !ctl_load && pd0_q) |=> (pen_irq_n && !ym_drv_en));

    assert_rearm_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (is_conv(state_q) && eoc_strobe && !ctl_load && !pd0_q) |=> (state_q == ST_IDLE_ARMED));

    assert_adc_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pd0_q |-> adc_en);

    assert_abort_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (is_conv(state_q) && !eoc_strobe && !ctl_load && !conv_active) |=> (state_q == ST_IDLE_QUIET));

endmodule

// File: rtl/pen_pwr_ctrl.sv
module pen_pwr_ctrl
    import pen_pwr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ctl_load,
    input  logic [PD_W-1:0] ctl_pd,
    input  logic            ctl_meas_pos,
    input  logic            conv_active,
    input  logic            eoc_strobe,
    input  logic            touch_raw,
    output logic            pen_irq_n,
    output logic            ref_en,
    output logic            adc_en,
    output logic            ym_drv_en,
    output logic            pullup_en
);

    logic pd0_q;
    logic touch_s;

    pen_ctl_reg u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (ctl_load),
        .pd_in (ctl_pd),
        .pd0_q (pd0_q),
        .ref_q (ref_en)
    );

    pen_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (touch_raw),
        .q_sync  (touch_s)
    );

    pen_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctl_load     (ctl_load),
        .ctl_meas_pos (ctl_meas_pos),
        .pd0_q        (pd0_q),
        .conv_active  (conv_active),
        .eoc_strobe   (eoc_strobe),
        .touch_s      (touch_s),
        .pen_irq_n    (pen_irq_n),
        .ym_drv_en    (ym_drv_en),
        .pullup_en    (pullup_en),
        .adc_en       (adc_en)
    );

endmodule

// File: tb/pen_pwr_ctrl_tb.sv
module pen_pwr_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_load = 1'b0;
    logic [1:0] ctl_pd = 2'b00;
    logic       ctl_meas_pos = 1'b0;
    logic       conv_active = 1'b0;
    logic       eoc_strobe = 1'b0;
    logic       touch_raw = 1'b0;
    logic       pen_irq_n, ref_en, adc_en, ym_drv_en, pullup_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Bench model: 0 armed idle, 1 quiet idle, 2 position conv, 3 aux conv
    int       m_st = 0;
    bit [1:0] m_pd = 2'b00;
    bit       m_ref = 1'b0;
    bit       m_s1 = 1'b0, m_s2 = 1'b0;

    always #5 clk = ~clk;

    pen_pwr_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .ctl_load(ctl_load), .ctl_pd(ctl_pd),
        .ctl_meas_pos(ctl_meas_pos), .conv_active(conv_active),
        .eoc_strobe(eoc_strobe), .touch_raw(touch_raw),
        .pen_irq_n(pen_irq_n), .ref_en(ref_en), .adc_en(adc_en),
        .ym_drv_en(ym_drv_en), .pullup_en(pullup_en)
    );

    function automatic bit exp_pen(int st, bit s2);
        case (st)
            0: return ~s2;
            2: return 1'b0;
            default: return 1'b1;
        endcase
    endfunction

    function automatic string pen_req(int st);
        case (st)
            0: return "R2";
            1: return "R5";
            2: return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic chk(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic check_all();
        chk(pen_req(m_st), "pen_irq_n", pen_irq_n, exp_pen(m_st, m_s2));
        chk((m_st == 2) ? "R3" : "R4", "pullup_en", pullup_en, m_st != 2);
        chk((m_st == 1) ? "R5" : "R1", "ym_drv_en", ym_drv_en, m_st == 0);
        chk("R8", "adc_en", adc_en, m_pd[0] | (m_st >= 2));
        chk("R7", "ref_en", ref_en, m_ref);
    endtask

    // Drive one cycle at negedge, then update the model after the posedge
    task automatic step(bit ld, bit [1:0] pd, bit pos, bit act, bit eoc, bit tch);
        ctl_load = ld; ctl_pd = pd; ctl_meas_pos = pos;
        conv_active = act; eoc_strobe = eoc; touch_raw = tch;
        @(posedge clk);
        m_s2 = m_s1; m_s1 = tch;
        if (ld) begin
            m_pd = pd; m_ref = pd[1]; m_st = pos ? 2 : 3;
        end else if (m_st >= 2) begin
            if (eoc) m_st = m_pd[0] ? 1 : 0;
            else if (!act) m_st = 1;
        end
        @(negedge clk);
        check_all();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "pen_irq_n reset", pen_irq_n, 1'b1);
        chk("R1", "ym reset", ym_drv_en, 1'b1);
        chk("R1", "pullup reset", pullup_en, 1'b1);
        chk("R1", "ref reset", ref_en, 1'b0);
        chk("R1", "adc reset", adc_en, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: touch reaches pin after two edges
        step(0, 0, 0, 0, 0, 1);
        chk("R2", "pen one edge after touch", pen_irq_n, 1'b1);
        step(0, 0, 0, 0, 0, 1);
        chk("R2", "pen two edges after touch", pen_irq_n, 1'b0);

        // R3: position conversion forces low, pd=10 sets reference
        step(1, 2'b10, 1, 1, 0, 0);
        chk("R3", "pos pen low", pen_irq_n, 1'b0);
        chk("R7", "ref on after load", ref_en, 1'b1);
        step(0, 2'b00, 0, 1, 0, 0);
        // R6: end strobe with bit0 clear re-arms
        step(0, 2'b00, 0, 1, 1, 1);
        chk("R6", "ym on after rearm", ym_drv_en, 1'b1);
        chk("R7", "ref held after conversion", ref_en, 1'b1);

        // R5: pd0=1 aux conversion, then quiet idle while touched
        step(1, 2'b01, 0, 1, 0, 1);
        chk("R4", "aux pen high", pen_irq_n, 1'b1);
        step(0, 2'b00, 0, 1, 1, 1);
        repeat (3) step(0, 2'b00, 0, 0, 0, 1);
        chk("R5", "quiet pen high while touched", pen_irq_n, 1'b1);
        chk("R8", "adc stays on pd0=1", adc_en, 1'b1);

        // R10 + load beats eoc in same cycle
        step(1, 2'b00, 0, 1, 0, 1);
        step(1, 2'b00, 1, 1, 1, 1);
        chk("R10", "retarget to position", pullup_en, 1'b0);
        // R9: abort does not re-arm
        step(0, 2'b00, 0, 0, 0, 1);
        chk("R9", "abort pen high", pen_irq_n, 1'b1);
        chk("R9", "abort ym off", ym_drv_en, 1'b0);
        // still quiet until a completed pd0=0 conversion
        step(1, 2'b00, 0, 1, 0, 1);
        step(0, 2'b00, 0, 1, 1, 1);
        chk("R6", "rearmed pen low on touch", pen_irq_n, 1'b0);

        // Constrained random phase
        for (int i = 0; i < 4000; i++) begin
            bit ld  = ($urandom_range(5) == 0);
            bit act = (m_st >= 2) ? ($urandom_range(15) != 0) : 1'b0;
            bit eoc = (m_st >= 2) ? ($urandom_range(7) == 0) : ($urandom_range(15) == 0);
            step(ld, 2'($urandom_range(3)), 1'($urandom_range(1)),
                 act | ld, eoc, ($urandom_range(3) != 0));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule